// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits at the input of the ALU in a five-stage in-order integer pipeline. For each of the two ALU operands it decides whether the register-file value read during decode is still current. If it is stale, the block substitutes a result that a later instruction has already produced but not yet written back. Two producers can supply such a result. The nearer one is the instruction now in the execute/memory register, which offers its ALU result. The farther one is the instruction in the memory/writeback register, which offers its final write-back value.

The selection is purely combinational. The block emits one 2-bit select code per operand, so that neighbouring logic can observe it. It also emits the chosen 64-bit operand. Both operands follow the same rules, and each is judged only against its own source register number. When both producers target the same source register, the nearer one wins, so that a run of dependent instructions always sees the newest value. Register zero is hard-wired, so a write to it is never forwarded.

Top module: `fwd_unit`

## Requirements
- R1: When neither producer qualifies for an operand, its select code is 00 and the operand equals the register-file value for that source.
- R2: A producer qualifies for an operand only when all three hold: its write enable is 1, its destination is nonzero, and its destination equals that operand's source number. When the execute/memory producer qualifies, the select code is 10 and the operand equals the execute/memory ALU result.
- R3: When only the memory/writeback producer qualifies, the select code is 01 and the operand equals the write-back value.
- R4: When both producers qualify for the same operand, the select code is 10 and the execute/memory result is used.
- R5: A producer whose write enable is 0 is never selected, whatever its destination.
- R6: A producer whose destination is register 0 is never selected, even with its write enable set and a source of 0.
- R7: The two operands are decided independently. Each operand's select code and value depend only on its own source number and its own register-file value.
- R8: In a chain of three dependent instructions on one register, the third instruction receives the second instruction's result, not the first one's.
- R9: Select code 11 never appears on either select output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register number in decode/execute register |
| ex_src_b | input | 5 | Second source register number in decode/execute register |
| rf_val_a | input | 64 | Register-file value read for the first source |
| rf_val_b | input | 64 | Register-file value read for the second source |
| em_we | input | 1 | Write enable of the execute/memory instruction |
| em_dst | input | 5 | Destination register of the execute/memory instruction |
| em_alu | input | 64 | ALU result held in the execute/memory register |
| mw_we | input | 1 | Write enable of the memory/writeback instruction |
| mw_dst | input | 5 | Destination register of the memory/writeback instruction |
| mw_val | input | 64 | Final write-back value in the memory/writeback register |
| sel_a | output | 2 | Select code for the first operand (00 rf, 10 execute/memory, 01 memory/writeback) |
| sel_b | output | 2 | Select code for the second operand, same encoding |
| opnd_a | output | 64 | Selected first ALU operand |
| opnd_b | output | 64 | Selected second ALU operand |

## Verification
The hardest case to reach is the double hazard. Both producers must have their write enables set and share one nonzero destination, and that destination must equal a source number. With uniformly random 5-bit register numbers this coincidence is rare. The random stimulus therefore draws register numbers from a small range that includes zero, so double hazards and register-zero writes occur often. Directed vectors add the three-instruction dependent chain, both enables low with matching destinations, and a source of zero against producers that write register zero.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    parameter int XLEN     = 64;
    parameter int NREGS    = 32;
    parameter int NUM_OPND = 2;
    localparam int REG_AW  = $clog2(NREGS);

    typedef logic [REG_AW-1:0] reg_idx_t;
    typedef logic [XLEN-1:0]   word_t;

    typedef enum logic [1:0] {
        SEL_RF    = 2'b00,
        SEL_MEMWB = 2'b01,
        SEL_EXMEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic     we;
        reg_idx_t dst;
        word_t    val;
    } producer_t;

    function automatic logic qualifies(input producer_t p, input reg_idx_t src);
        return p.we && (p.dst != '0) && (p.dst == src);
    endfunction
endpackage

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
(
    input  reg_idx_t  src,
    input  producer_t near_p,
    input  producer_t far_p,
    output fwd_sel_e  sel
);
    logic near_hit, far_hit;

    always_comb begin
        near_hit = qualifies(near_p, src);
        far_hit  = qualifies(far_p, src);
        if (near_hit)     sel = SEL_EXMEM;
        else if (far_hit) sel = SEL_MEMWB;
        else              sel = SEL_RF;
    end

    always_comb begin
        if (!near_p.we && !far_p.we)
            assert_no_writer_R5: assert (sel == SEL_RF)
                else $error("R5: select %b with no writer", sel);
        if (src == '0)
            assert_zero_src_R6: assert (sel == SEL_RF)
                else $error("R6: register zero forwarded, select %b", sel);
    end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
    import fwd_pkg::*;
(
    input  fwd_sel_e sel,
    input  word_t    rf_val,
    input  word_t    near_val,
    input  word_t    far_val,
    output word_t    y
);
    always_comb begin
        unique case (sel)
            SEL_EXMEM: y = near_val;
            SEL_MEMWB: y = far_val;
            default:   y = rf_val;
        endcase
    end

    always_comb begin
        if (sel == SEL_EXMEM)
            assert_pick_near_R2: assert (y == near_val)
                else $error("R2: operand mismatch on near path");
        if (sel == SEL_MEMWB)
            assert_pick_far_R3: assert (y == far_val)
                else $error("R3: operand mismatch on far path");
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
(
    input  logic [REG_AW-1:0] ex_src_a,
    input  logic [REG_AW-1:0] ex_src_b,
    input  logic [XLEN-1:0]   rf_val_a,
    input  logic [XLEN-1:0]   rf_val_b,
    input  logic              em_we,
    input  logic [REG_AW-1:0] em_dst,
    input  logic [XLEN-1:0]   em_alu,
    input  logic              mw_we,
    input  logic [REG_AW-1:0] mw_dst,
    input  logic [XLEN-1:0]   mw_val,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [XLEN-1:0]   opnd_a,
    output logic [XLEN-1:0]   opnd_b
);
    producer_t em_p, mw_p;
    reg_idx_t  src_w [NUM_OPND];
    word_t     rf_w  [NUM_OPND];
    fwd_sel_e  sel_w [NUM_OPND];
    word_t     op_w  [NUM_OPND];

    assign em_p     = '{we: em_we, dst: em_dst, val: em_alu};
    assign mw_p     = '{we: mw_we, dst: mw_dst, val: mw_val};
    assign src_w[0] = ex_src_a;
    assign src_w[1] = ex_src_b;
    assign rf_w[0]  = rf_val_a;
    assign rf_w[1]  = rf_val_b;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        fwd_select u_sel (
            .src    (src_w[g]),
            .near_p (em_p),
            .far_p  (mw_p),
            .sel    (sel_w[g])
        );
        fwd_operand_mux u_mux (
            .sel      (sel_w[g]),
            .rf_val   (rf_w[g]),
            .near_val (em_p.val),
            .far_val  (mw_p.val),
            .y        (op_w[g])
        );
    end

    assign sel_a  = sel_w[0];
    assign sel_b  = sel_w[1];
    assign opnd_a = op_w[0];
    assign opnd_b = op_w[1];

    always_comb begin
        if (em_we && mw_we && em_dst == mw_dst && em_dst != '0 && em_dst == ex_src_a)
            assert_newest_R4: assert (sel_a == 2'b10 && opnd_a == em_alu)
                else $error("R4: older producer won on operand a");
        assert_no_code3_R9: assert (sel_a != 2'b11 && sel_b != 2'b11)
            else $error("R9: reserved select code driven");
        if (sel_a == 2'b00)
            assert_rf_pass_R1: assert (opnd_a == rf_val_a)
                else $error("R1: operand a not from register file");
    end
endmodule

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [4:0]  ex_src_a, ex_src_b, em_dst, mw_dst;
    logic [63:0] rf_val_a, rf_val_b, em_alu, mw_val;
    logic        em_we, mw_we;
    logic [1:0]  sel_a, sel_b;
    logic [63:0] opnd_a, opnd_b;

    fwd_unit dut_i (
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
        .em_we(em_we), .em_dst(em_dst), .em_alu(em_alu),
        .mw_we(mw_we), .mw_dst(mw_dst), .mw_val(mw_val),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    typedef struct {
        logic [1:0]  sa, sb;
        logic [63:0] oa, ob;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // Reference: newer writer first, write enable required, register zero excluded.
    function automatic logic [1:0] ref_sel(input logic [4:0] src);
        if (em_we && em_dst != 5'd0 && em_dst == src) return 2'b10;
        if (mw_we && mw_dst != 5'd0 && mw_dst == src) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [63:0] ref_val(input logic [1:0] s, input logic [63:0] rf);
        case (s)
            2'b10:   return em_alu;
            2'b01:   return mw_val;
            default: return rf;
        endcase
    endfunction

    task automatic drive(input logic [4:0] sa, input logic [4:0] sb,
                         input logic ew, input logic [4:0] ed,
                         input logic mwe, input logic [4:0] md, input string req);
        exp_t e;
        @(negedge clk);
        ex_src_a = sa; ex_src_b = sb;
        em_we = ew; em_dst = ed; mw_we = mwe; mw_dst = md;
        rf_val_a = {$urandom, $urandom};
        rf_val_b = {$urandom, $urandom};
        em_alu   = {$urandom, $urandom};
        mw_val   = {$urandom, $urandom};
        e.sa  = ref_sel(sa);
        e.sb  = ref_sel(sb);
        e.oa  = ref_val(e.sa, rf_val_a);
        e.ob  = ref_val(e.sb, rf_val_b);
        e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: samples at the rising edge, half a period after the driver.
    always @(posedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (sel_a !== e.sa || sel_b !== e.sb || opnd_a !== e.oa || opnd_b !== e.ob) begin
                errors++;
                $display("FAIL %s: sel_a=%b sel_b=%b opnd_a=%h opnd_b=%h expected sel_a=%b sel_b=%b opnd_a=%h opnd_b=%h",
                         e.req, sel_a, sel_b, opnd_a, opnd_b, e.sa, e.sb, e.oa, e.ob);
            end
        end
    end

    initial begin
        ex_src_a = '0; ex_src_b = '0; em_dst = '0; mw_dst = '0;
        rf_val_a = '0; rf_val_b = '0; em_alu = '0; mw_val = '0;
        em_we = 1'b0; mw_we = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        drive(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, "R1 reset state");
        drive(5'd3, 5'd4, 1'b1, 5'd7, 1'b1, 5'd8, "R1 no match");
        drive(5'd5, 5'd6, 1'b1, 5'd5, 1'b0, 5'd0, "R2 near on a");
        drive(5'd9, 5'd9, 1'b0, 5'd0, 1'b1, 5'd9, "R3 far on both");
        drive(5'd11, 5'd2, 1'b1, 5'd11, 1'b1, 5'd11, "R4 double hazard");
        drive(5'd12, 5'd12, 1'b0, 5'd12, 1'b0, 5'd12, "R5 enables low");
        drive(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, "R6 register zero");
        drive(5'd13, 5'd14, 1'b1, 5'd14, 1'b1, 5'd13, "R7 split operands");
        // R8 chain on register 1: second op in EX, first op one stage ahead
        drive(5'd1, 5'd2, 1'b1, 5'd1, 1'b0, 5'd0, "R8 chain step2");
        // third op in EX, second in execute/memory, first in memory/writeback
        drive(5'd1, 5'd4, 1'b1, 5'd1, 1'b1, 5'd1, "R8 chain step3");
        for (int i = 0; i < 3000; i++)
            drive(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                  1'($urandom), 5'($urandom_range(0, 3)),
                  1'($urandom), 5'($urandom_range(0, 3)), "R9 random priority");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule